// File: doc/BRIEF.md
# Serial-Access Register File

This block is a small scratch memory of sixteen 20-bit registers read and written one bit per clock. Time is split into alternating 20-bit words: an instruction word (in_wa high) and a data word (in_wa low). The position of the bit inside the current word is given by the bit_pos input. Both timing signals come from outside the block.

During the instruction word, a 5-bit command arrives serially on cmd_in. Its low four bits name a register and its top bit asks for a write. The command takes effect only once the instruction word has ended. The chosen register then appears LSB first on rd_bit through the following data word and the following instruction word. During the data word, the bits on wr_bit replace the register's bits only if the write bit is set and wr_block is low. Otherwise the register keeps its value, so a read leaves the data intact.

The storage is held in parallel. The bit_pos input acts as the rotating pointer, so no register physically shifts.

Top module: `serial_regfile`

## Requirements
- R1: After reset every register reads as zero, register 0 is selected and writing is off, so a data word before the first command changes nothing.
- R2: Command bit k is taken from cmd_in at bit_pos k of the instruction word, for k = 0 to 4 (bits 3:0 are the register number and bit 4 is the write flag). Values on cmd_in at bit_pos 5 to 19 are ignored. The new command applies from the data word after bit_pos 19 of the instruction word.
- R3: rd_bit carries bit k of the selected register at bit_pos k, both during the data word and during the following instruction word.
- R4: With the write flag at 1, wr_bit at bit_pos k of the data word becomes bit k of the selected register. During that data word rd_bit still shows the old contents.
- R5: With the write flag at 0, the selected register keeps its value, however many times it is read.
- R6: A data-word bit with wr_block high is not written, even when the write flag is 1. The bits next to it are still written.
- R7: Registers other than the selected one never change.
- R8: Nothing is written during an instruction word, whatever wr_bit and wr_block are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_wa | input | 1 | 1 during the instruction word, 0 during the data word |
| bit_pos | input | 5 | Bit position 0..19 within the current word |
| cmd_in | input | 1 | Serial command bit |
| wr_bit | input | 1 | Serial write data bit |
| wr_block | input | 1 | Blocks writing of the current bit |
| rd_bit | output | 1 | Serial read data bit of the selected register |

## Verification
The bench builds the block with its default sixteen 20-bit registers, so every register number can be reached. A closing sweep reads back all sixteen registers and compares each with the bench's own model. That sweep catches writes that go to the wrong row and writes made during instruction words. Random commands carry random junk in bits 5 to 19 of the instruction word, which tests that those bits are ignored. Random per-bit block masks test partial writes within a single word.

// File: rtl/srf_pkg.sv
package srf_pkg;
  typedef enum logic {
    PH_DATA = 1'b0,
    PH_CMD  = 1'b1
  } srf_phase_e;
endpackage

// File: rtl/srf_cmd.sv
module srf_cmd #(
  parameter int ADDR_W    = 4,
  parameter int WORD_BITS = 20,
  parameter int POS_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  srf_pkg::srf_phase_e phase,
  input  logic [POS_W-1:0]  bit_pos,
  input  logic              cmd_in,
  output logic [ADDR_W-1:0] sel,
  output logic              wen
);
  localparam int CMD_W = ADDR_W + 1;

  logic [CMD_W-1:0]  shf_q, shf_d;
  logic [ADDR_W-1:0] sel_q, sel_d;
  logic              wen_q, wen_d;
  logic              end_of_cmd;

  assign end_of_cmd = (phase == srf_pkg::PH_CMD) &&
                      (bit_pos == POS_W'(WORD_BITS - 1));

  always_comb begin
    shf_d = shf_q;
    sel_d = sel_q;
    wen_d = wen_q;
    if (phase == srf_pkg::PH_CMD) begin
      for (int k = 0; k < CMD_W; k++) begin
        if (bit_pos == POS_W'(k)) shf_d[k] = cmd_in;
      end
    end
    if (end_of_cmd) begin
      sel_d = shf_q[ADDR_W-1:0];
      wen_d = shf_q[CMD_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shf_q <= '0;
      sel_q <= '0;
      wen_q <= 1'b0;
    end else begin
      shf_q <= shf_d;
      sel_q <= sel_d;
      wen_q <= wen_d;
    end
  end

  assign sel = sel_q;
  assign wen = wen_q;
endmodule

// File: rtl/srf_store.sv
module srf_store #(
  parameter int NUM_REGS  = 16,
  parameter int WORD_BITS = 20,
  parameter int ADDR_W    = 4,
  parameter int POS_W     = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             sel,
  input  logic [POS_W-1:0]              bit_pos,
  input  logic                          wr_bit,
  output logic [NUM_REGS*WORD_BITS-1:0] store_q
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
    logic [WORD_BITS-1:0] row_q, row_d;
    logic                 row_hit;

    assign row_hit = wr_en && (sel == ADDR_W'(r));

    always_comb begin
      row_d = row_q;
      if (row_hit) begin
        for (int b = 0; b < WORD_BITS; b++) begin
          if (bit_pos == POS_W'(b)) row_d[b] = wr_bit;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) row_q <= '0;
      else if (row_hit) row_q <= row_d;
    end

    assign store_q[r*WORD_BITS +: WORD_BITS] = row_q;
  end
endmodule

// File: rtl/srf_rdmux.sv
module srf_rdmux #(
  parameter int NUM_REGS  = 16,
  parameter int WORD_BITS = 20,
  parameter int ADDR_W    = 4,
  parameter int POS_W     = 5
) (
  input  logic [NUM_REGS*WORD_BITS-1:0] store_q,
  input  logic [ADDR_W-1:0]             sel,
  input  logic [POS_W-1:0]              bit_pos,
  output logic                          rd_bit
);
  logic [WORD_BITS-1:0] row;

  always_comb begin
    row = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (sel == ADDR_W'(r)) row = store_q[r*WORD_BITS +: WORD_BITS];
    end
  end

  always_comb begin
    rd_bit = 1'b0;
    for (int b = 0; b < WORD_BITS; b++) begin
      if (bit_pos == POS_W'(b)) rd_bit = row[b];
    end
  end
endmodule

// File: rtl/serial_regfile.sv
module serial_regfile #(
  parameter int NUM_REGS  = 16,
  parameter int WORD_BITS = 20,
  parameter int POS_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_wa,
  input  logic [POS_W-1:0] bit_pos,
  input  logic             cmd_in,
  input  logic             wr_bit,
  input  logic             wr_block,
  output logic             rd_bit
);
  localparam int ADDR_W = $clog2(NUM_REGS);

  srf_pkg::srf_phase_e          phase;
  logic [ADDR_W-1:0]             sel;
  logic                          wen;
  logic                          wr_en;
  logic [NUM_REGS*WORD_BITS-1:0] store_q;

  assign phase = in_wa ? srf_pkg::PH_CMD : srf_pkg::PH_DATA;
  assign wr_en = (phase == srf_pkg::PH_DATA) && wen && !wr_block;

  srf_cmd #(.ADDR_W(ADDR_W), .WORD_BITS(WORD_BITS), .POS_W(POS_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .phase(phase), .bit_pos(bit_pos),
    .cmd_in(cmd_in), .sel(sel), .wen(wen)
  );

  srf_store #(.NUM_REGS(NUM_REGS), .WORD_BITS(WORD_BITS), .ADDR_W(ADDR_W),
              .POS_W(POS_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .bit_pos(bit_pos),
    .wr_bit(wr_bit), .store_q(store_q)
  );

  srf_rdmux #(.NUM_REGS(NUM_REGS), .WORD_BITS(WORD_BITS), .ADDR_W(ADDR_W),
              .POS_W(POS_W)) u_rdmux (
    .store_q(store_q), .sel(sel), .bit_pos(bit_pos), .rd_bit(rd_bit)
  );
endmodule

// File: rtl/serial_regfile_chk.sv
module serial_regfile_chk #(
  parameter int NUM_REGS  = 16,
  parameter int WORD_BITS = 20,
  parameter int POS_W     = 5,
  parameter int ADDR_W    = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_wa,
  input logic [POS_W-1:0]              bit_pos,
  input logic                          wr_bit,
  input logic                          wr_block,
  input logic [ADDR_W-1:0]             sel,
  input logic                          wen,
  input logic [NUM_REGS*WORD_BITS-1:0] store_q
);
  localparam int IDX_W = $clog2(NUM_REGS * WORD_BITS);

  logic [IDX_W-1:0] wr_pos_q;
  logic             wr_val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pos_q <= '0;
      wr_val_q <= 1'b0;
    end else begin
      wr_pos_q <= IDX_W'(int'(sel) * WORD_BITS + int'(bit_pos));
      wr_val_q <= wr_bit;
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_wa && bit_pos == POS_W'(WORD_BITS - 1)) |=> ($stable(sel) && $stable(wen))); // R2
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_wa && wen && !wr_block && bit_pos < POS_W'(WORD_BITS)) |=> (store_q[wr_pos_q] == wr_val_q)); // R4
  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !wen |=> $stable(store_q)); // R5
  AST_BLOCK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_block |=> $stable(store_q)); // R6
  AST_CMD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    in_wa |=> $stable(store_q)); // R8
endmodule

bind serial_regfile serial_regfile_chk #(
  .NUM_REGS(NUM_REGS), .WORD_BITS(WORD_BITS), .POS_W(POS_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_wa(in_wa), .bit_pos(bit_pos), .wr_bit(wr_bit),
  .wr_block(wr_block), .sel(sel), .wen(wen), .store_q(store_q)
);

// File: tb/serial_regfile_tb.sv
module serial_regfile_tb;
  localparam int NREG = 16;
  localparam int WB   = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_wa = 1'b0;
  logic [4:0] bit_pos = '0;
  logic       cmd_in = 1'b0;
  logic       wr_bit = 1'b0;
  logic       wr_block = 1'b0;
  logic       rd_bit;

  int n_tests = 0;
  int n_fail  = 0;

  logic [WB-1:0] mdl [NREG];
  logic [3:0]    m_sel;
  logic          m_wen;

  always #2 clk = ~clk;

  serial_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .in_wa(in_wa), .bit_pos(bit_pos),
    .cmd_in(cmd_in), .wr_bit(wr_bit), .wr_block(wr_block), .rd_bit(rd_bit)
  );

  task automatic chk(input string req, input logic [WB-1:0] got, input logic [WB-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %05h expected %05h", req, got, exp);
    end
  endtask

  function automatic logic [WB-1:0] mdl_write(input logic [WB-1:0] old, input logic [WB-1:0] d,
                                             input logic [WB-1:0] blk, input logic en);
    return en ? ((old & blk) | (d & ~blk)) : old;
  endfunction

  // Instruction word: command in bits 4:0, bits 19:5 are junk the block must ignore.
  task automatic cmd_word(input logic [WB-1:0] cmd, input string req);
    logic [WB-1:0] got;
    for (int t = 0; t < WB; t++) begin
      @(negedge clk);
      in_wa    = 1'b1;
      bit_pos  = 5'(t);
      cmd_in   = cmd[t];
      wr_bit   = 1'($urandom);
      wr_block = 1'($urandom);
      #1 got[t] = rd_bit;
    end
    chk(req, got, mdl[m_sel]);
    m_sel = cmd[3:0];
    m_wen = cmd[4];
  endtask

  task automatic data_word(input logic [WB-1:0] d, input logic [WB-1:0] blk, input string req);
    logic [WB-1:0] got;
    for (int t = 0; t < WB; t++) begin
      @(negedge clk);
      in_wa    = 1'b0;
      bit_pos  = 5'(t);
      wr_bit   = d[t];
      wr_block = blk[t];
      cmd_in   = 1'($urandom);
      #1 got[t] = rd_bit;
    end
    chk(req, got, mdl[m_sel]);
    mdl[m_sel] = mdl_write(mdl[m_sel], d, blk, m_wen);
  endtask

  function automatic logic [WB-1:0] junk_cmd(input logic [4:0] c);
    return {15'($urandom), c};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1971));
    for (int r = 0; r < NREG; r++) mdl[r] = '0;
    m_sel = '0;
    m_wen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: data word before any command must not write register 0
    data_word(20'hFFFFF, 20'h0, "R1 reset read");
    cmd_word(junk_cmd(5'h13), "R1 reg0 still zero");
    // R4: write to register 3, old value seen during the write
    data_word(20'hA5C3E, 20'h0, "R4 old data during write");
    cmd_word(junk_cmd(5'h03), "R4 new data visible");
    // R5: read-only access keeps the value
    data_word(20'h12345, 20'h0, "R5 read-only");
    cmd_word(junk_cmd(5'h13), "R5 nondestructive");
    // R6: fully blocked write
    data_word(20'h0F0F0, 20'hFFFFF, "R6 blocked write");
    cmd_word(junk_cmd(5'h17), "R6 fully blocked kept");
    // R6: partly blocked write to register 7
    data_word(20'hFFFFF, 20'h00FF0, "R6 partial block");
    cmd_word(junk_cmd(5'h07), "R6 partial result");
    data_word(20'h0, 20'h0, "R3 read in data word");

    // R2/R3/R7/R8: random commands with junk upper bits, random data and masks
    for (int i = 0; i < 60; i++) begin
      logic [WB-1:0] blk;
      blk = (i % 3 == 0) ? 20'($urandom) : '0;
      cmd_word(junk_cmd(5'($urandom)), "R2 random command");
      data_word(20'($urandom), blk, "R3 random data word");
    end

    // R7/R8: sweep every register
    for (int r = 0; r < NREG; r++) begin
      cmd_word(junk_cmd(5'(r)), "R7 sweep prior");
      data_word(20'($urandom), 20'h0, "R7 sweep contents");
    end
    cmd_word(junk_cmd(5'h00), "R8 sweep tail");

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule